// File: doc/BRIEF.md
# LRU Jump Target Cache Encoder

This block sits in a trace encoder between the unit that spots uninferable program-counter discontinuities and the unit that formats packets. Each event carries the jump target address and a flag that says whether branch history travels with it. The block looks the target up in a small fully associative cache. On a hit it reports a short entry index in place of the address. On a miss it reports the full address and installs the address in the cache.

Every output descriptor carries a kind bit (address or index) and the branch-history flag, so either variant can hold either payload. The cache changes state only in response to the reported target stream, to the synchronisation input and to the enable input. An off-chip decoder that runs the same least-recently-used model can therefore turn every index back into an address. The descriptor appears one clock after the event.

Top module: `tgt_cache_encoder`

## Requirements
- R1: When an enabled event's target is not in the cache, the next cycle gives a descriptor with kind bit 0 (address), the target on the address field and 0 on the index field.
- R2: Replacement is least-recently-used. A hit makes the hit entry most recent. On a miss with every entry valid, the least recently reported entry is overwritten and becomes most recent.
- R3: When an enabled event's target is in the cache, the next cycle gives kind bit 1 (index), the entry number on the 3-bit index field and 0 on the address field.
- R4: While invalid entries remain, a miss fills the lowest-numbered invalid entry. After a reset, successive distinct targets occupy entries 0, 1, 2 and so on.
- R5: The descriptor's history flag equals the event's history flag for both kinds of descriptor.
- R6: With enable low, every event is reported as an address and the cache is left untouched: no install and no recency change.
- R7: A sync pulse invalidates all entries and restores the reset recency order. An event in the same cycle is reported as an address and is not installed.
- R8: After reset, and in any cycle after a cycle with no event, the valid and kind outputs are 0.
- R9: The descriptor is valid exactly one cycle after each event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Invalidate all entries (encoder/decoder resynchronisation) |
| enable_i | input | 1 | Cache use enable; low forces address reporting |
| evt_valid_i | input | 1 | Uninferable discontinuity event present |
| evt_hist_i | input | 1 | Branch history accompanies the event |
| evt_target_i | input | ADDR_W | Jump target address |
| pkt_valid_o | output | 1 | Descriptor valid |
| pkt_is_index_o | output | 1 | 1 = index payload, 0 = address payload |
| pkt_hist_o | output | 1 | Branch history flag of the descriptor |
| pkt_index_o | output | IDX_W | Cache entry number (index payload) |
| pkt_addr_o | output | ADDR_W | Target address (address payload) |

## Verification
The assertions assume that sync_i, enable_i and the event inputs are driven to known values in every cycle after reset. They also assume that the cache never holds two entries with the same address. That cannot happen here, because a target is installed only after it has missed. The stimulus changes inputs only on the falling clock edge and draws targets from a small pool, so that hits, misses, evictions, disabled events and sync pulses occur often.

// File: rtl/tgt_cache_pkg.sv
package tgt_cache_pkg;

   typedef enum logic {
      KIND_ADDR  = 1'b0,
      KIND_INDEX = 1'b1
   } pkt_kind_e;

endpackage

// File: rtl/tgt_cache_match.sv
module tgt_cache_match #(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0][ADDR_W-1:0] tags_i,
   input  logic [ENTRIES-1:0]             valid_i,
   input  logic [ADDR_W-1:0]              key_i,
   output logic                           hit_o,
   output logic [IDX_W-1:0]               hit_idx_o
);

   logic [ENTRIES-1:0] eq_vec;

   // one comparator per entry, all evaluated in the same cycle
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign eq_vec[g] = valid_i[g] && (tags_i[g] == key_i);
   end

   assign hit_o = |eq_vec;

   // entries are unique, so at most one bit is set and OR-encoding is safe
   always_comb begin
      hit_idx_o = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (eq_vec[i]) hit_idx_o = hit_idx_o | IDX_W'(i);
      end
   end

endmodule

// File: rtl/tgt_cache_lru.sv
module tgt_cache_lru #(
   parameter int ENTRIES = 8,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          clear_i,
   input  logic                          touch_i,
   input  logic [IDX_W-1:0]              touch_idx_i,
   input  logic [ENTRIES-1:0]            valid_i,
   output logic [IDX_W-1:0]              victim_idx_o,
   output logic [ENTRIES-1:0][IDX_W-1:0] ages_o
);

   localparam logic [IDX_W-1:0] OLDEST = IDX_W'(ENTRIES - 1);

   // ages form a permutation of 0..ENTRIES-1; 0 is most recent
   logic [ENTRIES-1:0][IDX_W-1:0] ages_q;
   logic [IDX_W-1:0]              touched_age;

   assign touched_age = ages_q[touch_idx_i];
   assign ages_o      = ages_q;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ages_q[g] <= IDX_W'(g);
         end else if (clear_i) begin
            ages_q[g] <= IDX_W'(g);
         end else if (touch_i) begin
            if (touch_idx_i == IDX_W'(g))
               ages_q[g] <= '0;
            else if (ages_q[g] < touched_age)
               ages_q[g] <= ages_q[g] + 1'b1;
         end
      end
   end

   // lowest invalid entry first, otherwise the oldest entry
   always_comb begin
      logic found_inv;
      found_inv    = 1'b0;
      victim_idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            victim_idx_o = IDX_W'(i);
            found_inv    = 1'b1;
         end
      end
      if (!found_inv) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (ages_q[i] == OLDEST) victim_idx_o = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/tgt_cache_encoder.sv
module tgt_cache_encoder
   import tgt_cache_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int ADDR_W  = 32,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_i,
   input  logic              enable_i,
   input  logic              evt_valid_i,
   input  logic              evt_hist_i,
   input  logic [ADDR_W-1:0] evt_target_i,
   output logic              pkt_valid_o,
   output logic              pkt_is_index_o,
   output logic              pkt_hist_o,
   output logic [IDX_W-1:0]  pkt_index_o,
   output logic [ADDR_W-1:0] pkt_addr_o
);

   if (ENTRIES < 2) begin : g_chk_min
      $error("tgt_cache_encoder: ENTRIES must be at least 2");
   end
   if ((1 << IDX_W) != ENTRIES) begin : g_chk_pow2
      $error("tgt_cache_encoder: ENTRIES must be a power of two");
   end
   if (ADDR_W <= IDX_W) begin : g_chk_width
      $error("tgt_cache_encoder: ADDR_W must exceed the index width");
   end

   logic [ENTRIES-1:0][ADDR_W-1:0] tags_q;
   logic [ENTRIES-1:0]             valid_q;
   logic [ENTRIES-1:0][IDX_W-1:0]  ages_w;
   logic                           hit;
   logic [IDX_W-1:0]               hit_idx;
   logic [IDX_W-1:0]               victim_idx;
   logic                           lookup;
   logic                           use_hit;
   logic                           install;
   logic [IDX_W-1:0]               touch_idx;
   pkt_kind_e                      kind;

   assign lookup    = evt_valid_i && enable_i && !sync_i;
   assign use_hit   = lookup && hit;
   assign install   = lookup && !hit;
   assign touch_idx = hit ? hit_idx : victim_idx;
   assign kind      = use_hit ? KIND_INDEX : KIND_ADDR;

   tgt_cache_match #(
      .ENTRIES (ENTRIES),
      .ADDR_W  (ADDR_W)
   ) u_match (
      .tags_i    (tags_q),
      .valid_i   (valid_q),
      .key_i     (evt_target_i),
      .hit_o     (hit),
      .hit_idx_o (hit_idx)
   );

   tgt_cache_lru #(
      .ENTRIES (ENTRIES)
   ) u_lru (
      .clk          (clk),
      .rst_n        (rst_n),
      .clear_i      (sync_i),
      .touch_i      (lookup),
      .touch_idx_i  (touch_idx),
      .valid_i      (valid_q),
      .victim_idx_o (victim_idx),
      .ages_o       (ages_w)
   );

   for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[g] <= 1'b0;
            tags_q[g]  <= '0;
         end else if (sync_i) begin
            valid_q[g] <= 1'b0;
         end else if (install && (victim_idx == IDX_W'(g))) begin
            valid_q[g] <= 1'b1;
            tags_q[g]  <= evt_target_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pkt_valid_o    <= 1'b0;
         pkt_is_index_o <= 1'b0;
         pkt_hist_o     <= 1'b0;
         pkt_index_o    <= '0;
         pkt_addr_o     <= '0;
      end else begin
         pkt_valid_o    <= evt_valid_i;
         pkt_is_index_o <= evt_valid_i && (kind == KIND_INDEX);
         pkt_hist_o     <= evt_valid_i && evt_hist_i;
         pkt_index_o    <= use_hit ? hit_idx : '0;
         pkt_addr_o     <= (evt_valid_i && !use_hit) ? evt_target_i : '0;
      end
   end

endmodule

// File: rtl/tgt_cache_checker.sv
module tgt_cache_checker #(
   parameter int ENTRIES = 8,
   parameter int IDX_W   = 3
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          sync_i,
   input logic                          enable_i,
   input logic                          evt_valid_i,
   input logic                          evt_hist_i,
   input logic                          pkt_valid_o,
   input logic                          pkt_is_index_o,
   input logic                          pkt_hist_o,
   input logic [ENTRIES-1:0]            valid_q,
   input logic [ENTRIES-1:0][IDX_W-1:0] ages_w
);

   logic [ENTRIES-1:0] oldest_mask;
   always_comb begin
      for (int i = 0; i < ENTRIES; i++)
         oldest_mask[i] = (ages_w[i] == IDX_W'(ENTRIES - 1));
   end

   assert_one_oldest_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_mask) == 1);

   assert_disabled_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_valid_i && !enable_i) |=> (pkt_valid_o && !pkt_is_index_o));

   assert_disabled_no_install_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable_i && !sync_i) |=> $stable(valid_q));

   assert_hist_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_i |=> (pkt_hist_o == $past(evt_hist_i)));

   assert_sync_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (valid_q == '0));

   assert_sync_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_i && evt_valid_i) |=> !pkt_is_index_o);

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !evt_valid_i |=> (!pkt_valid_o && !pkt_is_index_o));

   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_valid_i |=> pkt_valid_o);

endmodule

bind tgt_cache_encoder tgt_cache_checker #(
   .ENTRIES (ENTRIES),
   .IDX_W   (IDX_W)
) u_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .sync_i         (sync_i),
   .enable_i       (enable_i),
   .evt_valid_i    (evt_valid_i),
   .evt_hist_i     (evt_hist_i),
   .pkt_valid_o    (pkt_valid_o),
   .pkt_is_index_o (pkt_is_index_o),
   .pkt_hist_o     (pkt_hist_o),
   .valid_q        (valid_q),
   .ages_w         (ages_w)
);

// File: tb/tgt_cache_encoder_bench.sv
`timescale 1ns/1ps
module tgt_cache_encoder_bench;

   localparam int ENTRIES = 8;
   localparam int ADDR_W  = 32;
   localparam int IDX_W   = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              sync_i = 1'b0;
   logic              enable_i = 1'b1;
   logic              evt_valid_i = 1'b0;
   logic              evt_hist_i = 1'b0;
   logic [ADDR_W-1:0] evt_target_i = '0;
   logic              pkt_valid_o;
   logic              pkt_is_index_o;
   logic              pkt_hist_o;
   logic [IDX_W-1:0]  pkt_index_o;
   logic [ADDR_W-1:0] pkt_addr_o;

   int tests = 0;
   int fails = 0;

   bit                m_valid [ENTRIES];
   logic [ADDR_W-1:0] m_tag   [ENTRIES];
   int                m_age   [ENTRIES];

   always #5 clk = ~clk;

   tgt_cache_encoder #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_tgt_cache_encoder (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .enable_i(enable_i),
      .evt_valid_i(evt_valid_i), .evt_hist_i(evt_hist_i), .evt_target_i(evt_target_i),
      .pkt_valid_o(pkt_valid_o), .pkt_is_index_o(pkt_is_index_o), .pkt_hist_o(pkt_hist_o),
      .pkt_index_o(pkt_index_o), .pkt_addr_o(pkt_addr_o)
   );

   task automatic check(string req, string what, longint act, longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic m_clear();
      for (int i = 0; i < ENTRIES; i++) begin
         m_valid[i] = 1'b0;
         m_age[i]   = i;
      end
   endtask

   task automatic m_touch(int e);
      int a;
      a = m_age[e];
      for (int i = 0; i < ENTRIES; i++) begin
         if (i == e) m_age[i] = 0;
         else if (m_age[i] < a) m_age[i] = m_age[i] + 1;
      end
   endtask

   // reference behaviour built from R1-style requirement text
   task automatic m_step(logic [ADDR_W-1:0] t, output bit is_idx, output int idx);
      int h;
      int v;
      h = -1;
      is_idx = 1'b0;
      idx = 0;
      for (int i = 0; i < ENTRIES; i++)
         if (m_valid[i] && m_tag[i] == t) h = i;
      if (h >= 0) begin
         is_idx = 1'b1;
         idx = h;
         m_touch(h);
      end else begin
         v = -1;
         for (int i = ENTRIES - 1; i >= 0; i--) if (!m_valid[i]) v = i;
         if (v < 0) for (int i = 0; i < ENTRIES; i++) if (m_age[i] == ENTRIES - 1) v = i;
         m_valid[v] = 1'b1;
         m_tag[v]   = t;
         m_touch(v);
      end
   endtask

   bit obs_is_idx;
   int obs_idx;

   task automatic send(bit v, bit en, bit sy, bit h, logic [ADDR_W-1:0] t);
      bit ei;
      int ex;
      string req;
      ei = 1'b0;
      ex = 0;
      @(negedge clk);
      evt_valid_i = v; enable_i = en; sync_i = sy; evt_hist_i = h; evt_target_i = t;
      if (sy) m_clear();
      else if (v && en) m_step(t, ei, ex);
      @(posedge clk);
      #1;
      obs_is_idx = pkt_is_index_o;
      obs_idx    = int'(pkt_index_o);
      if (!v) begin
         check("R8", "valid when idle", pkt_valid_o, 0);
         check("R8", "kind when idle", pkt_is_index_o, 0);
      end else begin
         req = sy ? "R7" : (!en ? "R6" : (ei ? "R3" : "R1"));
         check("R9", "valid one cycle later", pkt_valid_o, 1);
         check(req, "kind", pkt_is_index_o, ei);
         check(req, "index field", pkt_index_o, ei ? ex : 0);
         check(req, "address field", pkt_addr_o, ei ? 0 : t);
         check("R5", "history flag", pkt_hist_o, h);
      end
   endtask

   logic [ADDR_W-1:0] pool [12];

   initial begin
      repeat (200000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      m_clear();
      repeat (3) @(posedge clk);
      #1;
      check("R8", "reset valid", pkt_valid_o, 0);
      check("R8", "reset kind", pkt_is_index_o, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R4: fill in order, then hit entries 0 and 3
      for (int i = 0; i < ENTRIES; i++) send(1, 1, 0, i[0], 32'h1000 + 32'(i) * 32'h40);
      send(1, 1, 0, 1, 32'h1000);
      check("R4", "first target entry", obs_idx, 0);
      send(1, 1, 0, 0, 32'h10C0);
      check("R4", "fourth target entry", obs_idx, 3);
      // R2: new target evicts entry 1 (oldest), then entry 1's old target goes to entry 2
      send(1, 1, 0, 0, 32'hBEEF0);
      send(1, 1, 0, 1, 32'hBEEF0);
      check("R2", "evicted slot reused", obs_idx, 1);
      send(1, 1, 0, 0, 32'h1040);
      check("R2", "evicted target misses", obs_is_idx, 0);
      send(1, 1, 0, 0, 32'h1040);
      check("R2", "reinstalled slot", obs_idx, 2);
      // R6: disabled hit and disabled miss leave cache alone
      send(1, 0, 0, 1, 32'h1000);
      send(1, 0, 0, 0, 32'h7777);
      send(1, 1, 0, 0, 32'h7777);
      check("R6", "disabled target not installed", obs_is_idx, 0);
      // R7: sync with event
      send(1, 1, 1, 1, 32'h1000);
      send(1, 1, 0, 0, 32'h1000);
      check("R7", "empty after sync", obs_is_idx, 0);
      send(1, 1, 0, 0, 32'h1000);
      check("R7", "refill from entry 0", obs_idx, 0);
      send(0, 1, 0, 0, 32'h0);

      for (int i = 0; i < 12; i++) pool[i] = 32'h8000 + 32'(i) * 32'h10;
      void'($urandom(32'd2024));
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom % 100);
         send(r < 90, r >= 8, r >= 97, $urandom % 2 == 0, pool[$urandom % 12]);
      end

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule